// File: doc/BRIEF.md
# Flash Programming Command Controller

This block sits between a CPU register bus and a flash array. Software loads a target address, a write word and a 7-bit operation code into the block's registers, then writes a start bit to launch the operation. Before anything reaches the array, the block checks the request. It validates the code, the address range, the address alignment, the brown-out state and the update permission of the targeted region. A request that fails any check is refused. A refusal sets one sticky fail flag, and the array never sees a request.

An accepted operation is presented to the array on a request/acknowledge port. The code, the address and the write word stay fixed until the array acknowledges. For codes that return a value, the acknowledged read word is captured into the data register. While an operation is outstanding, the block reports busy and does not accept new operands.

Three address regions are parameters: an application region, a configuration region and a secure region. An address outside all three is illegal for every operation that uses an address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every register reads 0, the busy bit reads 0 and `aReq` is low. The register indices are 0 control, 1 address, 2 data, 3 code, 4 start and 5 status. The control register holds the block enable in bit 0, the update-enables in bits 1 (application), 2 (configuration) and 3 (secure), and the fail flag in bit 4. The status register holds busy in bit 0 and the mirrored fail flag in bit 1.
- R2: When the enable bit is 1 and the block is idle, writing 1 to start bit 0 launches an accepted request. On the next cycle `aReq` is high, carrying the code register, the address register and the data register. Start bit 0 and status bit 0 read 1 until the operation completes.
- R3: `aReq` and its code, address and write word stay unchanged until `aAck` is sampled high. At that edge `aReq` falls and busy clears. For codes 0x00, 0x04, 0x0B, 0x0C and 0x0D, `aRdata` is captured into the data register at that edge. For all other codes the data register keeps its value.
- R4: Only the codes 0x00, 0x04, 0x0B, 0x0C, 0x0D, 0x21 (program word), 0x22 (erase page), 0x2D (start checksum) and 0x2E (vector remap) are valid. Starting any other code sets the fail flag, and no request is issued.
- R5: Every valid code except 0x04, 0x0B, 0x0C and 0x0D needs an address inside one of the three regions. Codes 0x00 and 0x21 also need address bits [1:0] to be zero, and code 0x2E needs bits [8:0] to be zero. A request that breaks any of these is refused with the fail flag set.
- R6: Code 0x21 or 0x22 started while `brownOut` is high is refused with the fail flag set. Read codes are not affected by `brownOut`.
- R7: Code 0x21 or 0x22 is refused with the fail flag set in three cases. The first is when it targets the configuration region while bit 2 is 0. The second is when it targets the secure region while bit 3 is 0. The third is when it targets the application region while `fromApp` is high and bit 1 is 0.
- R8: The fail flag stays set until a write carries 1 in control bit 4 or status bit 1. Writing 0 in those bits leaves it unchanged, and both register views show the same value.
- R9: While busy, writes to the address, data and code registers are ignored, and a further start write has no effect.
- R10: When the enable bit is 0, a start write issues no request and leaves the fail flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register index |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational on busAddr) |
| brownOut | input | 1 | Supply brown-out indication |
| fromApp | input | 1 | CPU is executing from the application region |
| aReq | output | 1 | Array request |
| aCmd | output | 7 | Array operation code |
| aAddr | output | 16 | Array address |
| aWdata | output | 32 | Array write word |
| aAck | input | 1 | Array acknowledge |
| aRdata | input | 32 | Array read word, valid with aAck |

## Verification
The bench builds the block with its default parameters. These give a 16-bit address and regions at 0x0000–0x7FFF (application), 0xC000–0xC0FF (configuration) and 0xD000–0xD1FF (secure). With these values, the legal space has holes that random addresses often land in, and the region boundaries and the 512-byte remap alignment are easy to reach. The array model acknowledges after a random 0 to 3 cycles, and it can be held off for a long time. The long hold exposes writes and repeated starts issued while busy.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam logic [6:0] CMD_READ   = 7'h00;
  localparam logic [6:0] CMD_UID    = 7'h04;
  localparam logic [6:0] CMD_MAKER  = 7'h0B;
  localparam logic [6:0] CMD_DEVID  = 7'h0C;
  localparam logic [6:0] CMD_SUMRD  = 7'h0D;
  localparam logic [6:0] CMD_PROG   = 7'h21;
  localparam logic [6:0] CMD_ERASE  = 7'h22;
  localparam logic [6:0] CMD_SUMRUN = 7'h2D;
  localparam logic [6:0] CMD_REMAP  = 7'h2E;

  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] REG_CTRL  = 3'd0;
  localparam logic [REG_IDX_W-1:0] REG_ADDR  = 3'd1;
  localparam logic [REG_IDX_W-1:0] REG_DATA  = 3'd2;
  localparam logic [REG_IDX_W-1:0] REG_CODE  = 3'd3;
  localparam logic [REG_IDX_W-1:0] REG_START = 3'd4;
  localparam logic [REG_IDX_W-1:0] REG_STAT  = 3'd5;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_APP_UE = 1;
  localparam int CTRL_CFG_UE = 2;
  localparam int CTRL_SEC_UE = 3;
  localparam int CTRL_FAIL   = 4;
  localparam int STAT_BUSY   = 0;
  localparam int STAT_FAIL   = 1;

  localparam int NUM_REGIONS = 3;
  localparam int RGN_APP = 0;
  localparam int RGN_CFG = 1;
  localparam int RGN_SEC = 2;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic refuse;   // reject the start request, set the fail flag
    logic finish;   // array acknowledged the outstanding request
  } fccStrobe_t;

  function automatic logic isValidCmd(input logic [6:0] c);
    case (c)
      CMD_READ, CMD_UID, CMD_MAKER, CMD_DEVID, CMD_SUMRD,
      CMD_PROG, CMD_ERASE, CMD_SUMRUN, CMD_REMAP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic isIdCmd(input logic [6:0] c);
    return (c == CMD_UID) || (c == CMD_MAKER) || (c == CMD_DEVID) || (c == CMD_SUMRD);
  endfunction

  function automatic logic returnsData(input logic [6:0] c);
    return (c == CMD_READ) || isIdCmd(c);
  endfunction

  function automatic logic isModify(input logic [6:0] c);
    return (c == CMD_PROG) || (c == CMD_ERASE);
  endfunction

  function automatic logic isWordOp(input logic [6:0] c);
    return (c == CMD_READ) || (c == CMD_PROG);
  endfunction

endpackage

// File: rtl/fcc_datapath.sv
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int unsigned APP_BASE = 'h0000,
  parameter int unsigned APP_SIZE = 'h8000,
  parameter int unsigned CFG_BASE = 'hC000,
  parameter int unsigned CFG_SIZE = 'h0100,
  parameter int unsigned SEC_BASE = 'hD000,
  parameter int unsigned SEC_SIZE = 'h0200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [REG_IDX_W-1:0] busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic                 brownOut,
  input  logic                 fromApp,
  input  logic                 busy,
  input  fccStrobe_t           strobe,
  output logic                 startReq,
  output logic                 checkOk,
  output logic                 failFlag,
  output logic [6:0]           cmdOut,
  output logic [ADDR_W-1:0]    addrOut,
  output logic [DATA_W-1:0]    wdataOut,
  input  logic [DATA_W-1:0]    arrRdata
);

  localparam logic [ADDR_W:0] R_LO [NUM_REGIONS] = '{
    (ADDR_W+1)'(APP_BASE), (ADDR_W+1)'(CFG_BASE), (ADDR_W+1)'(SEC_BASE)};
  localparam logic [ADDR_W:0] R_HI [NUM_REGIONS] = '{
    (ADDR_W+1)'(APP_BASE + APP_SIZE), (ADDR_W+1)'(CFG_BASE + CFG_SIZE),
    (ADDR_W+1)'(SEC_BASE + SEC_SIZE)};
  localparam int REMAP_ALIGN_W = 9;

  logic              enable, appUe, cfgUe, secUe;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [6:0]        cmdReg;

  logic wrCtrl, wrAddr, wrData, wrCode, wrStart, wrStat;
  assign wrCtrl  = busWe && (busAddr == REG_CTRL);
  assign wrAddr  = busWe && (busAddr == REG_ADDR) && !busy;
  assign wrData  = busWe && (busAddr == REG_DATA) && !busy;
  assign wrCode  = busWe && (busAddr == REG_CODE) && !busy;
  assign wrStart = busWe && (busAddr == REG_START) && busWdata[0];
  assign wrStat  = busWe && (busAddr == REG_STAT);

  assign startReq = wrStart && enable && !busy;

  // Region decode, one comparator pair per region.
  logic [NUM_REGIONS-1:0] inRegion;
  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : gRegion
      assign inRegion[g] = ({1'b0, addrReg} >= R_LO[g]) && ({1'b0, addrReg} < R_HI[g]);
    end
  endgenerate

  logic addrLegal, alignOk, permOk, brownOk;
  always_comb begin
    addrLegal = |inRegion;
    if (isWordOp(cmdReg))
      alignOk = (addrReg[1:0] == 2'b00);
    else if (cmdReg == CMD_REMAP)
      alignOk = (addrReg[REMAP_ALIGN_W-1:0] == '0);
    else
      alignOk = 1'b1;
    permOk = !(isModify(cmdReg) &&
               ((inRegion[RGN_APP] && fromApp && !appUe) ||
                (inRegion[RGN_CFG] && !cfgUe) ||
                (inRegion[RGN_SEC] && !secUe)));
    brownOk = !(isModify(cmdReg) && brownOut);
    checkOk = isValidCmd(cmdReg) && (isIdCmd(cmdReg) || (addrLegal && alignOk))
              && permOk && brownOk;
  end

  logic failClr;
  assign failClr = (wrCtrl && busWdata[CTRL_FAIL]) || (wrStat && busWdata[STAT_FAIL]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      appUe    <= 1'b0;
      cfgUe    <= 1'b0;
      secUe    <= 1'b0;
      addrReg  <= '0;
      dataReg  <= '0;
      cmdReg   <= '0;
      failFlag <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enable <= busWdata[CTRL_EN];
        appUe  <= busWdata[CTRL_APP_UE];
        cfgUe  <= busWdata[CTRL_CFG_UE];
        secUe  <= busWdata[CTRL_SEC_UE];
      end
      if (wrAddr) addrReg <= busWdata[ADDR_W-1:0];
      if (wrCode) cmdReg  <= busWdata[6:0];
      if (strobe.finish && returnsData(cmdReg)) dataReg <= arrRdata;
      else if (wrData) dataReg <= busWdata;
      if (strobe.refuse) failFlag <= 1'b1;
      else if (failClr)  failFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_CTRL: begin
        busRdata[CTRL_EN]     = enable;
        busRdata[CTRL_APP_UE] = appUe;
        busRdata[CTRL_CFG_UE] = cfgUe;
        busRdata[CTRL_SEC_UE] = secUe;
        busRdata[CTRL_FAIL]   = failFlag;
      end
      REG_ADDR:  busRdata = DATA_W'(addrReg);
      REG_DATA:  busRdata = dataReg;
      REG_CODE:  busRdata = DATA_W'(cmdReg);
      REG_START: busRdata[0] = busy;
      REG_STAT: begin
        busRdata[STAT_BUSY] = busy;
        busRdata[STAT_FAIL] = failFlag;
      end
      default: busRdata = '0;
    endcase
  end

  assign cmdOut   = cmdReg;
  assign addrOut  = addrReg;
  assign wdataOut = dataReg;

endmodule

// File: rtl/fcc_control.sv
module fcc_control
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       checkOk,
  input  logic       aAck,
  output logic       busy,
  output logic       aReq,
  output fccStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_ACTIVE} ctlState_t;
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (startReq && checkOk) stateNext = ST_ACTIVE;
      ST_ACTIVE: if (aAck) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy          = (state == ST_ACTIVE);
  assign aReq          = busy;
  assign strobe.refuse = (state == ST_IDLE) && startReq && !checkOk;
  assign strobe.finish = busy && aAck;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int unsigned APP_BASE = 'h0000,
  parameter int unsigned APP_SIZE = 'h8000,
  parameter int unsigned CFG_BASE = 'hC000,
  parameter int unsigned CFG_SIZE = 'h0100,
  parameter int unsigned SEC_BASE = 'hD000,
  parameter int unsigned SEC_SIZE = 'h0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              brownOut,
  input  logic              fromApp,
  output logic              aReq,
  output logic [6:0]        aCmd,
  output logic [ADDR_W-1:0] aAddr,
  output logic [DATA_W-1:0] aWdata,
  input  logic              aAck,
  input  logic [DATA_W-1:0] aRdata
);

  fccStrobe_t strobe;
  logic busy, startReq, checkOk, failFlag;

  fcc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .APP_BASE(APP_BASE), .APP_SIZE(APP_SIZE),
    .CFG_BASE(CFG_BASE), .CFG_SIZE(CFG_SIZE),
    .SEC_BASE(SEC_BASE), .SEC_SIZE(SEC_SIZE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .brownOut(brownOut),
    .fromApp(fromApp), .busy(busy), .strobe(strobe), .startReq(startReq),
    .checkOk(checkOk), .failFlag(failFlag), .cmdOut(aCmd), .addrOut(aAddr),
    .wdataOut(aWdata), .arrRdata(aRdata)
  );

  fcc_control u_control (
    .clk(clk), .rstN(rstN), .startReq(startReq), .checkOk(checkOk),
    .aAck(aAck), .busy(busy), .aReq(aReq), .strobe(strobe)
  );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [2:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              brownOut,
  input logic              aReq,
  input logic [6:0]        aCmd,
  input logic [ADDR_W-1:0] aAddr,
  input logic [DATA_W-1:0] aWdata,
  input logic              aAck,
  input logic              failFlag
);

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    aReq && !aAck |=> aReq && $stable(aCmd) && $stable(aAddr) && $stable(aWdata));

  assert_drop_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    aReq && aAck |=> !aReq);

  assert_valid_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aReq) |-> isValidCmd(aCmd));

  assert_refuse_no_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> !aReq);

  assert_word_align_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aReq) && isWordOp(aCmd) |-> aAddr[1:0] == 2'b00);

  assert_brownout_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aReq) && isModify(aCmd) |-> !$past(brownOut));

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failFlag) |-> $past(busWe) &&
      ((($past(busAddr) == REG_CTRL) && $past(busWdata[CTRL_FAIL])) ||
       (($past(busAddr) == REG_STAT) && $past(busWdata[STAT_FAIL]))));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .brownOut(brownOut), .aReq(aReq), .aCmd(aCmd), .aAddr(aAddr), .aWdata(aWdata),
  .aAck(aAck), .failFlag(failFlag)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        brownOut = 1'b0;
  logic        fromApp = 1'b0;
  logic        aReq;
  logic [6:0]  aCmd;
  logic [15:0] aAddr;
  logic [31:0] aWdata;
  logic        aAck = 1'b0;
  logic [31:0] aRdata = '0;

  int checks = 0;
  int errors = 0;
  bit holdLong = 0;
  int delayCnt = 0;
  logic [6:0]  mCmd;
  logic [15:0] mAddr;
  logic [31:0] mWdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .brownOut(brownOut), .fromApp(fromApp), .aReq(aReq),
    .aCmd(aCmd), .aAddr(aAddr), .aWdata(aWdata), .aAck(aAck), .aRdata(aRdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [6:0] c, input logic [15:0] a);
    return {c, 9'h0AB, a} ^ 32'h5A5A_0000;
  endfunction

  function automatic bit validCode(input logic [6:0] c);
    return c inside {7'h00, 7'h04, 7'h0B, 7'h0C, 7'h0D, 7'h21, 7'h22, 7'h2D, 7'h2E};
  endfunction

  function automatic bit returnsWord(input logic [6:0] c);
    return c inside {7'h00, 7'h04, 7'h0B, 7'h0C, 7'h0D};
  endfunction

  function automatic bit expectAccept(input logic [6:0] c, input logic [15:0] a,
      input logic [31:0] ctl, input bit bo, input bit fa);
    bit inApp, inCfg, inSec, modify, idOnly;
    inApp = a < 16'h8000;
    inCfg = a >= 16'hC000 && a < 16'hC100;
    inSec = a >= 16'hD000 && a < 16'hD200;
    modify = (c == 7'h21) || (c == 7'h22);
    idOnly = c inside {7'h04, 7'h0B, 7'h0C, 7'h0D};
    if (!validCode(c)) return 0;                                   // R4
    if (!idOnly && !(inApp || inCfg || inSec)) return 0;           // R5
    if ((c == 7'h00 || c == 7'h21) && a[1:0] != 0) return 0;       // R5
    if (c == 7'h2E && a[8:0] != 0) return 0;                       // R5
    if (modify && bo) return 0;                                    // R6
    if (modify && inCfg && !ctl[2]) return 0;                      // R7
    if (modify && inSec && !ctl[3]) return 0;                      // R7
    if (modify && inApp && fa && !ctl[1]) return 0;                // R7
    return 1;
  endfunction

  // Array model: acknowledges after 0..3 cycles, or much later when held.
  always @(negedge clk) begin
    if (aAck) aAck = 1'b0;
    else if (aReq) begin
      if (delayCnt == 0 && !holdLong) begin
        aAck = 1'b1;
        aRdata = modelRead(aCmd, aAddr);
        check(aCmd == mCmd && aAddr == mAddr && aWdata == mWdata, "R2",
              "array request fields", {aCmd, 9'd0, aAddr}, {mCmd, 9'd0, mAddr});
      end else if (delayCnt > 0) delayCnt--;
    end else delayCnt = $urandom % 4;
  end

  task automatic busWrite(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk);
    busWe = 1'b1; busAddr = idx; busWdata = v;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] idx, output logic [31:0] v);
    busAddr = idx;
    #1;
    v = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] st;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      busRead(3'd5, st);
      if (!st[0]) return;
    end
    check(0, "R3", "busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic runOp(input logic [6:0] c, input logic [15:0] a, input logic [31:0] d,
      input logic [31:0] ctl, input bit bo, input bit fa, input string req);
    logic [31:0] st, rd;
    bit ok, expBusy, prevFail, expFail;
    busWrite(3'd0, ctl & 32'h0000_000F);
    brownOut = bo; fromApp = fa;
    busWrite(3'd1, {16'd0, a});
    busWrite(3'd2, d);
    busWrite(3'd3, {25'd0, c});
    busRead(3'd5, st);
    prevFail = st[1];
    ok = expectAccept(c, a, ctl, bo, fa);
    mCmd = c; mAddr = a; mWdata = d;
    busWrite(3'd4, 32'd1);
    busRead(3'd5, st);
    expBusy = ctl[0] && ok;
    expFail = ctl[0] ? (prevFail || !ok) : prevFail;
    check(st[0] == expBusy, req, "busy after start", st, {31'd0, expBusy});
    check(st[1] == expFail, req, "fail after start", st, {30'd0, expFail, 1'b0});
    check(aReq == expBusy, req, "aReq after start", {31'd0, aReq}, {31'd0, expBusy});
    if (expBusy) begin
      waitIdle();
      busRead(3'd2, rd);
      check(rd == (returnsWord(c) ? modelRead(c, a) : d), "R3", "data after finish",
            rd, returnsWord(c) ? modelRead(c, a) : d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [6:0] codeList [9] = '{7'h00, 7'h04, 7'h0B, 7'h0C, 7'h0D, 7'h21, 7'h22, 7'h2D, 7'h2E};

  initial begin
    logic [31:0] v;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int i = 0; i < 6; i++) begin
      busRead(3'(i), v);
      check(v == 0, "R1", "register after reset", v, 32'd0);
    end
    check(aReq == 0, "R1", "aReq after reset", {31'd0, aReq}, 32'd0);

    // R2/R3 directed: read and program in the application region
    runOp(7'h00, 16'h0100, 32'h1111_2222, 32'hF, 0, 0, "R2");
    runOp(7'h21, 16'h0104, 32'hCAFE_F00D, 32'hF, 0, 1, "R2");
    runOp(7'h0C, 16'hFFFF, 32'h0, 32'hF, 0, 0, "R2");
    busWrite(3'd5, 32'h2);
    // R4: invalid code
    runOp(7'h7F, 16'h0000, 32'h0, 32'hF, 0, 0, "R4");
    busWrite(3'd5, 32'h2);
    // R5: misaligned word, remap misaligned, out of range, region edge
    runOp(7'h21, 16'h0102, 32'h0, 32'hF, 0, 0, "R5");
    busWrite(3'd5, 32'h2);
    runOp(7'h2E, 16'h0300, 32'h0, 32'hF, 0, 0, "R5");
    busWrite(3'd5, 32'h2);
    runOp(7'h2E, 16'h0400, 32'h0, 32'hF, 0, 0, "R5");
    runOp(7'h00, 16'h8000, 32'h0, 32'hF, 0, 0, "R5");
    busWrite(3'd5, 32'h2);
    runOp(7'h00, 16'hD1FC, 32'h0, 32'hF, 0, 0, "R5");
    // R6: brown-out blocks erase, not read
    runOp(7'h22, 16'h0200, 32'h0, 32'hF, 1, 0, "R6");
    busWrite(3'd5, 32'h2);
    runOp(7'h00, 16'h0200, 32'h0, 32'hF, 1, 0, "R6");
    // R7: region permissions
    runOp(7'h21, 16'hC010, 32'h5, 32'hB, 0, 0, "R7");
    busWrite(3'd5, 32'h2);
    runOp(7'h22, 16'hD000, 32'h5, 32'h7, 0, 0, "R7");
    busWrite(3'd5, 32'h2);
    runOp(7'h21, 16'h0010, 32'h5, 32'hD, 0, 1, "R7");
    busWrite(3'd5, 32'h2);
    runOp(7'h21, 16'h0010, 32'h5, 32'hD, 0, 0, "R7");

    // R8: sticky fail, both clear paths, writing 0 does nothing
    runOp(7'h55, 16'h0, 32'h0, 32'hF, 0, 0, "R8");
    busWrite(3'd0, 32'h0000_000F);
    busRead(3'd0, v);
    check(v[4] == 1, "R8", "fail kept after write of 0", v, 32'h1F);
    busRead(3'd5, v);
    check(v[1] == 1, "R8", "mirror shows fail", v, 32'h2);
    busWrite(3'd5, 32'h2);
    busRead(3'd0, v);
    check(v[4] == 0, "R8", "cleared through status", v, 32'h0F);
    runOp(7'h55, 16'h0, 32'h0, 32'hF, 0, 0, "R8");
    busWrite(3'd0, 32'h0000_001F);
    busRead(3'd5, v);
    check(v[1] == 0, "R8", "cleared through control", v, 32'h0);

    // R9: operand writes and a second start while busy
    holdLong = 1;
    busWrite(3'd0, 32'hF);
    busWrite(3'd1, 32'h0040);
    busWrite(3'd2, 32'h1234_5678);
    busWrite(3'd3, 32'h21);
    mCmd = 7'h21; mAddr = 16'h0040; mWdata = 32'h1234_5678;
    busWrite(3'd4, 32'd1);
    busWrite(3'd1, 32'h0080);
    busWrite(3'd2, 32'hDEAD_BEEF);
    busWrite(3'd3, 32'h7F);
    busWrite(3'd4, 32'd1);
    busRead(3'd1, v);
    check(v == 32'h0040, "R9", "address held while busy", v, 32'h0040);
    busRead(3'd2, v);
    check(v == 32'h1234_5678, "R9", "data held while busy", v, 32'h1234_5678);
    busRead(3'd3, v);
    check(v == 32'h21, "R9", "code held while busy", v, 32'h21);
    busRead(3'd5, v);
    check(v == 32'h1, "R9", "still busy, no fail", v, 32'h1);
    holdLong = 0;
    waitIdle();
    busRead(3'd5, v);
    check(v == 32'h0, "R9", "idle after finish", v, 32'h0);

    // R10: disabled start is ignored, with fail both clear and set
    runOp(7'h7F, 16'h0, 32'h0, 32'hE, 0, 0, "R10");
    runOp(7'h00, 16'h0, 32'h0, 32'hE, 0, 0, "R10");
    runOp(7'h7F, 16'h0, 32'h0, 32'hF, 0, 0, "R10");
    runOp(7'h7F, 16'h0, 32'h0, 32'hE, 0, 0, "R10");
    busWrite(3'd5, 32'h2);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [6:0] c;
      logic [15:0] a;
      logic [31:0] ctl;
      int pick;
      c = ($urandom % 5 == 0) ? 7'($urandom) : codeList[$urandom % 9];
      pick = $urandom % 6;
      case (pick)
        0: a = 16'($urandom % 16'h8000) & 16'hFFFC;
        1: a = 16'hC000 + (16'($urandom % 16'h100) & 16'hFFFC);
        2: a = 16'hD000 + (16'($urandom % 16'h200) & 16'hFFFC);
        3: a = 16'($urandom % 16'h8000);
        4: a = 16'h8000 + 16'($urandom % 16'h4000);
        default: a = 16'($urandom % 64) << 9;
      endcase
      ctl = {28'd0, 4'($urandom)} | (($urandom % 8 != 0) ? 32'h1 : 32'h0);
      runOp(c, a, $urandom, ctl, ($urandom % 4 == 0), $urandom % 2, "R7");
      busWrite(3'd5, 32'h2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule